// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one general-purpose I/O port of up to sixteen pins. Software reaches it through a small memory-mapped register interface. Each access is a single cycle: a write enable or a read enable, a word address and a 32-bit data word. The interface has no back-pressure. A write takes effect at the clock edge where the enable is high. Read data is combinational and is valid in the same cycle as the read enable. The reads and writes carry configuration and status, not a data stream, so the port has no valid/ready handshake.

Per-pin fields choose the direction (input or output), the output driver type (push-pull or open-drain) and a pull resistor (none, up or down). Software writes the stored output data directly. It can also change it atomically through a set/clear register or a clear-only register. Each pin has an external side made of three signals: a drive strobe with a level, and a release input. These signals record whether an outside driver is attached to the pin and what level it applies. The block resolves one level per pin from all of this state. It presents the result on the `pin_level` output toward the system, and software can read it in the input data register.

Reset values of the mode and pull registers, and the level a floating unpulled pin reads, are parameters. This lets each port instance come out of reset in its own state.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Word addresses are: mode 0, output type 1, pull 3, input data 4, output data 5, set/clear 6, clear-only 10. A read of any other address returns zero, and `reg_rdata` is zero whenever `reg_re` is low.
- R2: After reset: mode = `MODE_RST`, pull = `PULL_RST`, output type = 0, output data = 0, and no pin has a connected external driver.
- R3: Set/clear register write: bit n (n < 16) set to 1 sets output data bit n. Bit n+16 set to 1 clears it. If both are 1 in one write, the bit ends up set. Zero bits leave output data unchanged.
- R4: A write of 1 to bit n of the clear-only register clears output data bit n. Zero bits leave output data unchanged.
- R5: Output data written while a pin is an input is kept. That value drives the pin as soon as its mode field becomes 01.
- R6: A push-pull output pin (mode 01, output type bit 0) takes the output data level and ignores external drive. Its connected flag is cleared, so the pin reads as floating after it returns to input mode.
- R7: Open-drain output pin (output type bit 1):
  - Output data 0 gives level 0.
  - With output data 1, a connected external low gives 0, and that driver stays connected.
  - An external high is dropped (the pin becomes disconnected). The pin then reads as floating.
- R8: In input mode (mode 00, 10 or 11), a pin with a connected driver follows the driver's level. Output data has no effect on an input pin.
- R9: A floating pin reads according to its 2-bit pull field: 01 gives 1, 10 gives 0, and 00 or 11 give bit n of `FLOAT_DFLT`.
- R10: The input data register (bits 15:0) always equals `pin_level`. Both reflect a register write or external event from the next clock edge on.
- R11: Writes to the input data address change no state.
- R12: A drive strobe on a pin marks it connected and latches `ext_level`. A release clears the connected flag. A strobe and a release on the same pin in the same cycle leave the pin connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| ext_strobe | input | NPINS | Per-pin external drive event |
| ext_level | input | NPINS | Level applied with the drive event |
| ext_release | input | NPINS | Per-pin driver release |
| pin_level | output | NPINS | Resolved level of every pin |

## Verification
The checker checks four things on every cycle:
- Every push-pull output pin matches its output data bit.
- No open-drain pin with output data 0 is high.
- A push-pull pin has no connected driver one cycle after it is configured.
- Set/clear and clear-only writes move the output data bits they name, with set winning.

It also checks that input data reads match `pin_level`. Only the bench scenarios can show the full resolution table across modes and pulls. They also show:
- A driver being kept or dropped across a mode change.
- Stored output data surviving input mode.
- The strobe-versus-release ordering.
- Writes to the input data address being ignored.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned GP_ADDR_W = 4;

  localparam logic [GP_ADDR_W-1:0] IDX_MODE   = 4'd0;
  localparam logic [GP_ADDR_W-1:0] IDX_OTYPE  = 4'd1;
  localparam logic [GP_ADDR_W-1:0] IDX_PULL   = 4'd3;
  localparam logic [GP_ADDR_W-1:0] IDX_LEVEL  = 4'd4;
  localparam logic [GP_ADDR_W-1:0] IDX_OUTDAT = 4'd5;
  localparam logic [GP_ADDR_W-1:0] IDX_SETCLR = 4'd6;
  localparam logic [GP_ADDR_W-1:0] IDX_CLR    = 4'd10;

  localparam int unsigned CLR_LANE = 16;

  typedef enum logic [1:0] {
    DIR_IN  = 2'b00,
    DIR_OUT = 2'b01,
    DIR_X2  = 2'b10,
    DIR_X3  = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS    = 16,
  parameter logic [31:0] MODE_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] PULL_RST = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [GP_ADDR_W-1:0] addr,
  input  logic [31:0]          wdata,
  output logic [2*NPINS-1:0]   mode_q,
  output logic [NPINS-1:0]     otype_q,
  output logic [2*NPINS-1:0]   pull_q,
  output logic [NPINS-1:0]     odr_q
);
  localparam int unsigned FW = 2 * NPINS;

  logic [NPINS-1:0] odr_d;

  always_comb begin
    odr_d = odr_q;
    if (we) begin
      unique case (addr)
        IDX_OUTDAT: odr_d = wdata[NPINS-1:0];
        IDX_SETCLR: odr_d = (odr_q & ~wdata[CLR_LANE +: NPINS]) | wdata[NPINS-1:0];
        IDX_CLR:    odr_d = odr_q & ~wdata[NPINS-1:0];
        default:    odr_d = odr_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST[FW-1:0];
      pull_q  <= PULL_RST[FW-1:0];
      otype_q <= '0;
      odr_q   <= '0;
    end else begin
      odr_q <= odr_d;
      if (we && addr == IDX_MODE)  mode_q  <= wdata[FW-1:0];
      if (we && addr == IDX_PULL)  pull_q  <= wdata[FW-1:0];
      if (we && addr == IDX_OTYPE) otype_q <= wdata[NPINS-1:0];
    end
  end
endmodule

// File: rtl/gpio_link_track.sv
module gpio_link_track #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] strobe,
  input  logic [NPINS-1:0] level_in,
  input  logic [NPINS-1:0] release_in,
  input  logic [NPINS-1:0] is_out,
  input  logic [NPINS-1:0] is_od,
  output logic [NPINS-1:0] conn_q,
  output logic [NPINS-1:0] lvl_q
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic c_d, l_d;

    always_comb begin
      c_d = conn_q[p];
      l_d = lvl_q[p];
      if (release_in[p]) c_d = 1'b0;
      if (strobe[p]) begin
        c_d = 1'b1;
        l_d = level_in[p];
      end
      // an output that would fight the driver drops it
      if (is_out[p] && (!is_od[p] || l_d)) c_d = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        conn_q[p] <= 1'b0;
        lvl_q[p]  <= 1'b0;
      end else begin
        conn_q[p] <= c_d;
        lvl_q[p]  <= l_d;
      end
    end
  end
endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_port_pkg::*;
#(
  parameter int unsigned      NPINS      = 16,
  parameter logic [NPINS-1:0] FLOAT_DFLT = '0
) (
  input  logic [2*NPINS-1:0] mode,
  input  logic [NPINS-1:0]   otype,
  input  logic [2*NPINS-1:0] pull,
  input  logic [NPINS-1:0]   odr,
  input  logic [NPINS-1:0]   conn,
  input  logic [NPINS-1:0]   ext_lvl,
  output logic [NPINS-1:0]   level,
  output logic [NPINS-1:0]   is_out,
  output logic [NPINS-1:0]   pp_mask,
  output logic [NPINS-1:0]   od_mask
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    dir_e  dir;
    pull_e pl;
    logic  flt;

    assign dir = dir_e'(mode[2*p +: 2]);
    assign pl  = pull_e'(pull[2*p +: 2]);

    always_comb begin
      unique case (pl)
        PULL_UP:   flt = 1'b1;
        PULL_DOWN: flt = 1'b0;
        default:   flt = FLOAT_DFLT[p];
      endcase
    end

    assign is_out[p]  = (dir == DIR_OUT);
    assign pp_mask[p] = is_out[p] && !otype[p];
    assign od_mask[p] = is_out[p] && otype[p];

    always_comb begin
      if (!is_out[p])                  level[p] = conn[p] ? ext_lvl[p] : flt;
      else if (!otype[p])              level[p] = odr[p];
      else if (!odr[p])                level[p] = 1'b0;
      else if (conn[p] && !ext_lvl[p]) level[p] = 1'b0;
      else                             level[p] = flt;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned      NPINS      = 16,
  parameter logic [31:0]      MODE_RST   = 32'hABFF_FFFF,
  parameter logic [31:0]      PULL_RST   = 32'h6400_0000,
  parameter logic [NPINS-1:0] FLOAT_DFLT = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [GP_ADDR_W-1:0] reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NPINS-1:0]     ext_strobe,
  input  logic [NPINS-1:0]     ext_level,
  input  logic [NPINS-1:0]     ext_release,
  output logic [NPINS-1:0]     pin_level
);
  localparam int unsigned FW = 2 * NPINS;

  logic [FW-1:0]    mode_q, pull_q;
  logic [NPINS-1:0] otype_q, odr_q, conn_q, lvl_q;
  logic [NPINS-1:0] is_out, pp_mask, od_mask;

  gpio_cfg_regs #(
    .NPINS(NPINS), .MODE_RST(MODE_RST), .PULL_RST(PULL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q), .odr_q(odr_q)
  );

  gpio_link_track #(.NPINS(NPINS)) u_link (
    .clk(clk), .rst_n(rst_n), .strobe(ext_strobe), .level_in(ext_level),
    .release_in(ext_release), .is_out(is_out), .is_od(otype_q),
    .conn_q(conn_q), .lvl_q(lvl_q)
  );

  gpio_pin_resolve #(.NPINS(NPINS), .FLOAT_DFLT(FLOAT_DFLT)) u_res (
    .mode(mode_q), .otype(otype_q), .pull(pull_q), .odr(odr_q),
    .conn(conn_q), .ext_lvl(lvl_q), .level(pin_level),
    .is_out(is_out), .pp_mask(pp_mask), .od_mask(od_mask)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      unique case (reg_addr)
        IDX_MODE:   reg_rdata[FW-1:0]    = mode_q;
        IDX_OTYPE:  reg_rdata[NPINS-1:0] = otype_q;
        IDX_PULL:   reg_rdata[FW-1:0]    = pull_q;
        IDX_LEVEL:  reg_rdata[NPINS-1:0] = pin_level;
        IDX_OUTDAT: reg_rdata[NPINS-1:0] = odr_q;
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic                 reg_re,
  input logic [GP_ADDR_W-1:0] reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [NPINS-1:0]     pin_level,
  input logic [NPINS-1:0]     odr,
  input logic [NPINS-1:0]     conn,
  input logic [NPINS-1:0]     pp_mask,
  input logic [NPINS-1:0]     od_mask
);
  assert_setclr_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == IDX_SETCLR) |=>
      ((odr & $past(reg_wdata[NPINS-1:0])) == $past(reg_wdata[NPINS-1:0])));

  assert_clr_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == IDX_CLR) |=> ((odr & $past(reg_wdata[NPINS-1:0])) == '0));

  assert_pushpull_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_level ^ odr) & pp_mask) == '0);

  assert_pushpull_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((conn & $past(pp_mask)) == '0));

  assert_opendrain_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & od_mask & ~odr) == '0);

  assert_level_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == IDX_LEVEL) |-> (reg_rdata[NPINS-1:0] == pin_level));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pin_level(pin_level), .odr(odr_q), .conn(conn_q),
  .pp_mask(pp_mask), .od_mask(od_mask)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] M_RST = 32'hABFF_FFFF;
  localparam logic [31:0] P_RST = 32'h6400_0000;
  localparam logic [15:0] LVL_RST = 16'hA010; // 15 up, 14 down, 13 up, 4 default 1
  localparam int PIN = 5;
  localparam int NV = 15;
  // {mode[1:0], otype, pull[1:0], odr, drive_en, drive, expected}
  localparam logic [8:0] VEC [NV] = '{
    9'b00_0_00_0_1_1_1, 9'b00_0_00_0_1_0_0, 9'b00_0_01_0_0_0_1,
    9'b00_0_10_0_0_0_0, 9'b00_0_00_0_0_0_0, 9'b10_0_01_0_0_0_1,
    9'b11_0_00_0_1_1_1, 9'b01_0_00_1_1_0_1, 9'b01_0_00_0_1_1_0,
    9'b01_1_00_0_1_1_0, 9'b01_1_00_1_1_0_0, 9'b01_1_01_1_1_1_1,
    9'b01_1_10_1_0_0_0, 9'b00_0_11_0_0_0_0, 9'b00_0_10_1_0_0_0
  };

  logic clk = 0, rst_n = 0, reg_we = 0, reg_re = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] ext_strobe = '0, ext_level = '0, ext_release = '0, pin_level;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_strobe(ext_strobe), .ext_level(ext_level),
    .ext_release(ext_release), .pin_level(pin_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a; #1 d = reg_rdata;
    reg_re = 0;
  endtask

  task automatic drive(input int p, input logic v, input logic rel);
    @(negedge clk); ext_strobe[p] = 1; ext_level[p] = v; ext_release[p] = rel;
    @(negedge clk); ext_strobe[p] = 0; ext_release[p] = 0;
  endtask

  task automatic release_pin(input int p);
    @(negedge clk); ext_release[p] = 1;
    @(negedge clk); ext_release[p] = 0;
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 6:              return "R8";
      7, 8:                 return "R6";
      9, 10, 11, 12:        return "R7";
      default:              return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset state
    rd(4'd0, r);  chk("R2 mode", r, M_RST);
    rd(4'd3, r);  chk("R2 pull", r, P_RST);
    rd(4'd1, r);  chk("R2 otype", r, 0);
    rd(4'd5, r);  chk("R2 outdata", r, 0);
    rd(4'd4, r);  chk("R9 reset levels", r, {16'h0, LVL_RST});
    @(negedge clk); #1 chk("R10 pin_level reset", {16'h0, pin_level}, {16'h0, LVL_RST});

    // table of pin resolution cases on PIN
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      logic [15:0] ex;
      v = VEC[i];
      release_pin(PIN);
      wr(4'd0, (M_RST & ~(32'h3 << 2*PIN)) | (32'(v[8:7]) << 2*PIN));
      wr(4'd1, 32'(v[6]) << PIN);
      wr(4'd3, (P_RST & ~(32'h3 << 2*PIN)) | (32'(v[5:4]) << 2*PIN));
      wr(4'd5, 32'(v[3]) << PIN);
      if (v[2]) drive(PIN, v[1], 1'b0);
      ex = (LVL_RST & ~(16'h1 << PIN)) | (16'(v[0]) << PIN);
      rd(4'd4, r);
      chk(vec_tag(i), r, {16'h0, ex});
      #1 chk("R10 pin_level", {16'h0, pin_level}, {16'h0, ex});
    end
    wr(4'd0, M_RST); wr(4'd1, 0); wr(4'd3, P_RST); wr(4'd5, 0);
    release_pin(PIN);

    // R3 set/clear with set priority
    wr(4'd5, 32'h0010);
    wr(4'd6, (32'h1 << 3) | (32'h1 << 19) | (32'h1 << 20));
    rd(4'd5, r); chk("R3 set wins", r, 32'h0008);
    wr(4'd6, 32'h1 << 19);
    rd(4'd5, r); chk("R3 clear", r, 32'h0000);

    // R4 clear-only
    wr(4'd5, 32'hFFFF);
    wr(4'd10, 32'h00F0);
    rd(4'd5, r); chk("R4 clear-only", r, 32'hFF0F);
    wr(4'd5, 0);

    // R5 stored data kept in input mode
    wr(4'd5, 32'h1 << 6);
    rd(4'd4, r); chk("R5 input ignores outdata", r, {16'h0, LVL_RST});
    wr(4'd0, (M_RST & ~(32'h3 << 12)) | (32'h1 << 12));
    rd(4'd4, r); chk("R5 stored data drives", r, {16'h0, LVL_RST | 16'h0040});
    wr(4'd0, M_RST); wr(4'd5, 0);

    // R11 write to level address ignored; R1 unmapped and idle reads
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, r); chk("R11 level write ignored", r, {16'h0, LVL_RST});
    rd(4'd5, r); chk("R11 outdata untouched", r, 0);
    rd(4'd2, r); chk("R1 unmapped 2", r, 0);
    rd(4'd7, r); chk("R1 unmapped 7", r, 0);
    @(negedge clk); reg_addr = 4'd0; #1 chk("R1 no read enable", reg_rdata, 0);

    // R12 strobe / release ordering on pin 7 (input, no pull, default 0)
    drive(7, 1'b1, 1'b0);
    rd(4'd4, r); chk("R12 strobe connects", r, {16'h0, LVL_RST | 16'h0080});
    release_pin(7);
    rd(4'd4, r); chk("R12 release", r, {16'h0, LVL_RST});
    drive(7, 1'b1, 1'b1);
    rd(4'd4, r); chk("R12 strobe beats release", r, {16'h0, LVL_RST | 16'h0080});
    release_pin(7);

    // R6 push-pull drops driver: pin 8
    drive(8, 1'b1, 1'b0);
    wr(4'd0, (M_RST & ~(32'h3 << 16)) | (32'h1 << 16));
    rd(4'd4, r); chk("R6 push-pull ignores high", r, {16'h0, LVL_RST});
    wr(4'd0, M_RST);
    rd(4'd4, r); chk("R6 driver dropped", r, {16'h0, LVL_RST});

    // R7 open-drain keeps low driver: pin 9 with pull-up
    wr(4'd3, P_RST | (32'h1 << 18));
    drive(9, 1'b0, 1'b0);
    rd(4'd4, r); chk("R7 low driver on input", r, {16'h0, LVL_RST});
    wr(4'd5, 32'h1 << 9);
    wr(4'd1, 32'h1 << 9);
    wr(4'd0, (M_RST & ~(32'h3 << 18)) | (32'h1 << 18));
    rd(4'd4, r); chk("R7 open-drain low held", r, {16'h0, LVL_RST});
    wr(4'd0, M_RST);
    rd(4'd4, r); chk("R7 low driver still connected", r, {16'h0, LVL_RST});
    release_pin(9);
    rd(4'd4, r); chk("R9 pull-up after release", r, {16'h0, LVL_RST | 16'h0200});

    done = 1;
    summary();
  end
endmodule